// File: doc/BRIEF.md
# Calendar Real-Time Clock

This block keeps wall-clock time and a calendar date: seconds, minutes, hours, day of month, month, a 12-bit year and a weekday. A one-second enable input advances it. Carries run from seconds all the way up to the year, using the real month lengths and the Gregorian leap-year rule. Software reaches the clock over a small synchronous register bus. Reads are combinational from the registered state, and a write takes effect at the rising clock edge on which write enable is high.

New values are not written straight into the running counters. Software stages them in a time-set register or a date-set register. Each of these carries a hold flag (bit 24) and a commit strobe (bit 25). The expected sequence is: hold, then hold with commit, then hold alone, then both cleared. The clock does not advance while either hold flag is set. The commit copies the staged fields into the live counters. A date commit also takes the year from the separate year register.

The live time and live date always change on the same clock edge. Software that reads time, then date, then time again and sees the two time values equal therefore holds a date that matches that time.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, the live clock reads 00:00:00 on day 1, month 1, year 2000, weekday 6. The time-set and date-set registers read 0, and the year register reads 2000.
- R2: On each cycle with the tick input high and no hold flag set, seconds step by one. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day.
- R3: A day carry moves day 1 forward to the month length and then back to 1 in the next month. Months 4, 6, 9 and 11 have 30 days and February has 28. February has 29 days in years divisible by 4, except years divisible by 100 but not by 400.
- R4: A day carry out of month 12 sets the month to 1 and adds one to the year, modulo 4096. The year changes at no other time except a date commit.
- R5: Weekday (1 to 7, with Sunday as 7) steps by one on every day carry and wraps from 7 to 1. A weekday of 0 written to a date commit is stored as 7, so the live weekday is never 0.
- R6: While bit 24 (hold) of the time-set register (offset 0x00) or of the date-set register (offset 0x04) is 1, ticks leave the live time and date unchanged.
- R7: A write to offset 0x00 with bits 24 and 25 both 1 is a time commit. It loads hours from bits 20:16, minutes from 13:8 and seconds from 5:0 into the live clock, and the new time is visible from the next cycle.
- R8: A write to offset 0x04 with bits 24 and 25 both 1 is a date commit. It loads month from bits 19:16, weekday from 10:8 and day from 4:0, and takes the year from the year register (offset 0x08, bits 11:0). Writing the year register alone does not change the live date.
- R9: Set registers read back their stored fields and bits 25:24 at the write positions. The year register reads back bits 11:0. All other bits read 0, and any offset other than 0x00, 0x04, 0x08, 0x10 and 0x14 reads 0.
- R10: Offset 0x10 returns the live time with hours in 20:16, minutes in 13:8 and seconds in 5:0. Offset 0x14 returns month in 27:24, weekday in 23:21, day in 20:16 and year in 11:0.
- R11: Writes to offsets 0x10 and 0x14 have no effect on the live time or date.
- R12: On a day carry, the zeroed time and the new date appear on the same clock edge.
- R13: A commit takes place only when bit 25 of that set register goes from 0 to 1. Writing bits 24 and 25 again while the stored bit 25 is already 1 updates the staged fields but does not load them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1s | input | 1 | One-cycle enable, once per second |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from address and state |

## Verification
Read data depends only on the address and the registers, so it is valid in the same cycle the address is driven. Writes and ticks act at the next rising edge. The bench therefore drives every input just after a falling edge and samples read data 1 ns after a later falling edge. A commit or a tick is checked by reading in the cycle that follows its rising edge. The effect of a hold flag or of an ignored write is read back through the bus before the next stimulus can mask it.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int RTC_YEAR_W    = 12;
  localparam int RTC_OFF_TSET  = 'h00;
  localparam int RTC_OFF_DSET  = 'h04;
  localparam int RTC_OFF_YEAR  = 'h08;
  localparam int RTC_OFF_CTIME = 'h10;
  localparam int RTC_OFF_CDATE = 'h14;
  localparam int RTC_BIT_HOLD  = 24;
  localparam int RTC_BIT_COMMIT = 25;

  typedef struct packed {
    logic [4:0] hr;
    logic [5:0] mi;
    logic [5:0] se;
  } rtc_time_t;

  typedef struct packed {
    logic [3:0] mo;
    logic [2:0] wd;
    logic [4:0] dy;
  } rtc_date_t;

  function automatic logic rtc_is_leap(input logic [15:0] y);
    return (((y % 16'd4) == 16'd0) && ((y % 16'd100) != 16'd0)) ||
           ((y % 16'd400) == 16'd0);
  endfunction

  function automatic logic [4:0] rtc_month_len(input logic [3:0] m, input logic leap);
    case (m)
      4'd2:                     return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:  return 5'd30;
      default:                  return 5'd31;
    endcase
  endfunction

  function automatic logic [2:0] rtc_next_wday(input logic [2:0] w);
    return (w >= 3'd7) ? 3'd1 : w + 3'd1;
  endfunction

  function automatic logic [31:0] rtc_pack_time(input rtc_time_t t);
    return {11'd0, t.hr, 2'd0, t.mi, 2'd0, t.se};
  endfunction

  function automatic logic [31:0] rtc_pack_cdate(input rtc_date_t d,
                                                 input logic [RTC_YEAR_W-1:0] y);
    return {4'd0, d.mo, d.wd, d.dy, 4'd0, y};
  endfunction

endpackage

// File: rtl/rtc_set_regs.sv
module rtc_set_regs
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 32,
  parameter int RESET_YEAR = 2000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_we,
  input  logic [DATA_W-1:0]     bus_wdata,
  output rtc_time_t             tset_q,
  output rtc_date_t             dset_q,
  output logic [RTC_YEAR_W-1:0] year_q,
  output logic [1:0]            hold_q,
  output logic [1:0]            commit_q,
  output logic                  load_time,
  output logic                  load_date,
  output rtc_time_t             time_new,
  output rtc_date_t             date_new
);

  localparam int N_SET = 2;

  logic [N_SET-1:0] wr_sel;
  logic [N_SET-1:0] commit_edge;
  logic             wr_year;
  rtc_date_t        date_raw;

  assign wr_sel[0] = bus_we && (bus_addr == ADDR_W'(RTC_OFF_TSET));
  assign wr_sel[1] = bus_we && (bus_addr == ADDR_W'(RTC_OFF_DSET));
  assign wr_year   = bus_we && (bus_addr == ADDR_W'(RTC_OFF_YEAR));

  for (genvar g = 0; g < N_SET; g++) begin : g_ctrl
    logic hold_r, commit_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_r   <= 1'b0;
        commit_r <= 1'b0;
      end else if (wr_sel[g]) begin
        hold_r   <= bus_wdata[RTC_BIT_HOLD];
        commit_r <= bus_wdata[RTC_BIT_COMMIT];
      end
    end
    assign hold_q[g]      = hold_r;
    assign commit_q[g]    = commit_r;
    assign commit_edge[g] = wr_sel[g] & bus_wdata[RTC_BIT_HOLD] &
                            bus_wdata[RTC_BIT_COMMIT] & ~commit_r;
  end

  assign load_time = commit_edge[0];
  assign load_date = commit_edge[1];

  assign time_new = '{hr: bus_wdata[20:16], mi: bus_wdata[13:8], se: bus_wdata[5:0]};
  assign date_raw = '{mo: bus_wdata[19:16], wd: bus_wdata[10:8], dy: bus_wdata[4:0]};

  always_comb begin
    date_new = date_raw;
    if (date_raw.wd == 3'd0) date_new.wd = 3'd7;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tset_q <= '0;
      dset_q <= '0;
      year_q <= RTC_YEAR_W'(RESET_YEAR);
    end else begin
      if (wr_sel[0]) tset_q <= time_new;
      if (wr_sel[1]) dset_q <= date_raw;
      if (wr_year)   year_q <= bus_wdata[RTC_YEAR_W-1:0];
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[DATA_W-1:26], bus_wdata[23:21], bus_wdata[15:14]};

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_cal_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      advance,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t cur,
  output logic      hr_wrap
);

  logic sec_wrap, min_wrap;

  assign sec_wrap = cur.se >= 6'd59;
  assign min_wrap = sec_wrap && (cur.mi >= 6'd59);
  assign hr_wrap  = min_wrap && (cur.hr >= 5'd23);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (load) begin
      cur <= load_val;
    end else if (advance) begin
      if (!sec_wrap) begin
        cur.se <= cur.se + 6'd1;
      end else begin
        cur.se <= 6'd0;
        if (!min_wrap) begin
          cur.mi <= cur.mi + 6'd1;
        end else begin
          cur.mi <= 6'd0;
          cur.hr <= hr_wrap ? 5'd0 : cur.hr + 5'd1;
        end
      end
    end
  end

endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_cal_pkg::*;
#(
  parameter int RESET_YEAR = 2000,
  parameter int RESET_WDAY = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step,
  input  logic                  load,
  input  rtc_date_t             load_val,
  input  logic [RTC_YEAR_W-1:0] load_year,
  output rtc_date_t             cur,
  output logic [RTC_YEAR_W-1:0] year
);

  logic       leap;
  logic [4:0] month_len;
  logic       day_wrap, mon_wrap;

  assign leap      = rtc_is_leap(16'(year));
  assign month_len = rtc_month_len(cur.mo, leap);
  assign day_wrap  = cur.dy >= month_len;
  assign mon_wrap  = day_wrap && (cur.mo >= 4'd12);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur  <= '{mo: 4'd1, wd: 3'(RESET_WDAY), dy: 5'd1};
      year <= RTC_YEAR_W'(RESET_YEAR);
    end else if (load) begin
      cur  <= load_val;
      year <= load_year;
    end else if (step) begin
      cur.wd <= rtc_next_wday(cur.wd);
      if (!day_wrap) begin
        cur.dy <= cur.dy + 5'd1;
      end else begin
        cur.dy <= 5'd1;
        if (mon_wrap) begin
          cur.mo <= 4'd1;
          year   <= year + 1'b1;
        end else begin
          cur.mo <= cur.mo + 4'd1;
        end
      end
    end
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 32,
  parameter int RESET_YEAR = 2000,
  parameter int RESET_WDAY = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1s,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  rtc_time_t             tset_q, time_new, cur_time;
  rtc_date_t             dset_q, date_new, cur_date;
  logic [RTC_YEAR_W-1:0] year_q, cur_year;
  logic [1:0]            hold_q, commit_q;
  logic                  load_time, load_date, load_any;
  logic                  paused, advance, hr_wrap, day_carry;

  rtc_set_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_YEAR(RESET_YEAR)
  ) u_set (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .tset_q(tset_q), .dset_q(dset_q), .year_q(year_q),
    .hold_q(hold_q), .commit_q(commit_q), .load_time(load_time),
    .load_date(load_date), .time_new(time_new), .date_new(date_new)
  );

  assign paused    = |hold_q;
  assign load_any  = load_time | load_date;
  assign advance   = tick_1s & ~paused & ~load_any;
  assign day_carry = advance & hr_wrap;

  rtc_time_chain u_time (
    .clk(clk), .rst_n(rst_n), .advance(advance), .load(load_time),
    .load_val(time_new), .cur(cur_time), .hr_wrap(hr_wrap)
  );

  rtc_date_chain #(
    .RESET_YEAR(RESET_YEAR), .RESET_WDAY(RESET_WDAY)
  ) u_date (
    .clk(clk), .rst_n(rst_n), .step(day_carry), .load(load_date),
    .load_val(date_new), .load_year(year_q), .cur(cur_date), .year(cur_year)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(RTC_OFF_TSET):
        bus_rdata = DATA_W'({6'd0, commit_q[0], hold_q[0], 3'd0, tset_q.hr,
                             2'd0, tset_q.mi, 2'd0, tset_q.se});
      ADDR_W'(RTC_OFF_DSET):
        bus_rdata = DATA_W'({6'd0, commit_q[1], hold_q[1], 4'd0, dset_q.mo,
                             5'd0, dset_q.wd, 3'd0, dset_q.dy});
      ADDR_W'(RTC_OFF_YEAR):  bus_rdata = DATA_W'(year_q);
      ADDR_W'(RTC_OFF_CTIME): bus_rdata = DATA_W'(rtc_pack_time(cur_time));
      ADDR_W'(RTC_OFF_CDATE): bus_rdata = DATA_W'(rtc_pack_cdate(cur_date, cur_year));
      default:                bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_cal_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick_1s,
  input logic [DATA_W-1:0]     bus_wdata,
  input rtc_time_t             cur_time,
  input rtc_date_t             cur_date,
  input logic [RTC_YEAR_W-1:0] cur_year,
  input logic                  paused,
  input logic                  load_time,
  input logic                  load_date,
  input logic                  day_carry
);

  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && !load_time && !load_date) |=>
      ($stable(cur_time) && $stable(cur_date) && $stable(cur_year))); // R6

  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1s && !load_time && !load_date) |=>
      ($stable(cur_time) && $stable(cur_date) && $stable(cur_year))); // R11

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1s && !paused && !load_time && !load_date && cur_time.se < 6'd59) |=>
      (cur_time.se == $past(cur_time.se) + 6'd1 && $stable(cur_time.mi) &&
       $stable(cur_time.hr))); // R2

  AST_DAY_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry |=> (cur_time == '0 && cur_date.dy != $past(cur_date.dy))); // R12

  AST_WDAY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cur_date.wd != 3'd0); // R5

  AST_TIME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_time |=> (cur_time.hr == $past(bus_wdata[20:16]) &&
                   cur_time.mi == $past(bus_wdata[13:8]) &&
                   cur_time.se == $past(bus_wdata[5:0]))); // R7

  AST_YEAR_ONLY_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_date && !day_carry) |=> $stable(cur_year)); // R4

endmodule

bind rtc_calendar rtc_calendar_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .bus_wdata(bus_wdata),
  .cur_time(cur_time), .cur_date(cur_date), .cur_year(cur_year),
  .paused(paused), .load_time(load_time), .load_date(load_date),
  .day_carry(day_carry)
);

// File: tb/tb_rtc_calendar.sv
module tb_rtc_calendar;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1s = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_checks = 0;
  int n_errors = 0;

  localparam logic [31:0] HOLD   = 32'h0100_0000;
  localparam logic [31:0] COMMIT = 32'h0200_0000;

  always #2 clk = ~clk;

  rtc_calendar dut (
    .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  typedef struct packed {
    int hh; int mm; int ss; int dd; int mo; int wd; int yr; int nt;
    int eh; int em; int es; int ed; int emo; int ew; int ey;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{12,34,56, 15, 6,3,2023, 1, 12,34,57, 15, 6,3,2023},
    '{10,59,59, 15, 6,3,2023, 1, 11, 0, 0, 15, 6,3,2023},
    '{23,59,59, 28, 2,2,2023, 1,  0, 0, 0,  1, 3,3,2023},
    '{23,59,59, 28, 2,3,2024, 1,  0, 0, 0, 29, 2,4,2024},
    '{23,59,59, 28, 2,3,1900, 1,  0, 0, 0,  1, 3,4,1900},
    '{23,59,59, 28, 2,1,2000, 1,  0, 0, 0, 29, 2,2,2000},
    '{23,59,59, 30, 4,7,2023, 1,  0, 0, 0,  1, 5,1,2023},
    '{23,59,59, 31,12,7,2023, 1,  0, 0, 0,  1, 1,1,2024},
    '{23,59,59, 31, 1,2,2023, 1,  0, 0, 0,  1, 2,3,2023},
    '{ 0, 0,58, 10,10,5,2023, 3,  0, 1, 1, 10,10,5,2023},
    '{23,59,59, 29, 2,4,2024, 1,  0, 0, 0,  1, 3,5,2024},
    '{23,59,59, 31,12,7,4095, 1,  0, 0, 0,  1, 1,1,   0}
  };

  function automatic logic [31:0] f_time(int h, int m, int s);
    return 32'(h * 65536 + m * 256 + s);
  endfunction
  function automatic logic [31:0] f_dset(int d, int mo, int wd);
    return 32'(mo * 65536 + wd * 256 + d);
  endfunction
  function automatic logic [31:0] f_cdate(int d, int mo, int wd, int y);
    return 32'(mo * 16777216 + wd * 2097152 + d * 65536 + y);
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_addr = 5'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 5'(a);
    #1 d = bus_rdata;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1s = 1'b1;
      @(negedge clk); tick_1s = 1'b0;
    end
  endtask

  task automatic load_all(int h, int m, int s, int d, int mo, int wd, int y);
    wr('h08, 32'(y));
    wr('h04, f_dset(d, mo, wd) | HOLD);
    wr('h04, f_dset(d, mo, wd) | HOLD | COMMIT);
    wr('h04, f_dset(d, mo, wd) | HOLD);
    wr('h00, f_time(h, m, s) | HOLD);
    wr('h00, f_time(h, m, s) | HOLD | COMMIT);
    wr('h00, f_time(h, m, s) | HOLD);
    wr('h00, f_time(h, m, s));
    wr('h04, f_dset(d, mo, wd));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R10 layouts, R9 readback of set registers
    rd('h10, v); check("R1", "live time after reset", v, 32'h0);
    rd('h14, v); check("R1", "live date after reset", v, f_cdate(1, 1, 6, 2000));
    rd('h00, v); check("R1", "time-set after reset", v, 32'h0);
    rd('h04, v); check("R1", "date-set after reset", v, 32'h0);
    rd('h08, v); check("R1", "year reg after reset", v, 32'd2000);
    rd('h0C, v); check("R9", "unmapped 0x0C", v, 32'h0);
    rd('h18, v); check("R9", "unmapped 0x18", v, 32'h0);

    // R2 basic stepping
    ticks(2);
    rd('h10, v); check("R2", "two ticks", v, f_time(0, 0, 2));

    // R6 hold via time-set register, then via date-set register
    wr('h00, HOLD);
    ticks(3);
    rd('h10, v); check("R6", "time-set hold", v, f_time(0, 0, 2));
    rd('h00, v); check("R9", "hold bit readback", v, HOLD);
    wr('h00, 32'h0);
    wr('h04, HOLD);
    ticks(1);
    rd('h10, v); check("R6", "date-set hold", v, f_time(0, 0, 2));
    wr('h04, 32'h0);
    ticks(1);
    rd('h10, v); check("R6", "runs after release", v, f_time(0, 0, 3));

    // R9 field readback with all-ones data, hold but no commit
    wr('h00, 32'hFDFF_FFFF);
    rd('h00, v); check("R9", "time-set readback", v, 32'h011F_3F3F);
    wr('h04, 32'hFDFF_FFFF);
    rd('h04, v); check("R9", "date-set readback", v, 32'h010F_071F);
    wr('h08, 32'hFFFF_FFFF);
    rd('h08, v); check("R9", "year readback", v, 32'h0000_0FFF);
    wr('h00, 32'h0);
    wr('h04, 32'h0);
    rd('h10, v); check("R7", "no commit without bit 25", v, f_time(0, 0, 3));
    rd('h14, v); check("R8", "year reg alone leaves date", v, f_cdate(1, 1, 6, 2000));

    // R11 writes to live registers ignored
    wr('h10, 32'h0012_3456);
    wr('h14, 32'h0FFF_FFFF);
    rd('h10, v); check("R11", "live time write ignored", v, f_time(0, 0, 3));
    rd('h14, v); check("R11", "live date write ignored", v, f_cdate(1, 1, 6, 2000));

    // R7 commit, R13 no reload while commit bit stays set
    wr('h00, f_time(1, 2, 3) | HOLD);
    wr('h00, f_time(1, 2, 3) | HOLD | COMMIT);
    rd('h10, v); check("R7", "time commit", v, f_time(1, 2, 3));
    wr('h00, f_time(4, 5, 6) | HOLD | COMMIT);
    rd('h10, v); check("R13", "repeat commit no load", v, f_time(1, 2, 3));
    rd('h00, v); check("R13", "staged fields updated", v, f_time(4, 5, 6) | HOLD | COMMIT);
    wr('h00, f_time(4, 5, 6) | HOLD);
    wr('h00, 32'h0);

    // R5 weekday 0 stored as 7, R8 year taken from year register
    wr('h08, 32'd2000);
    wr('h04, f_dset(5, 3, 0) | HOLD);
    wr('h04, f_dset(5, 3, 0) | HOLD | COMMIT);
    wr('h04, 32'h0);
    rd('h14, v); check("R5", "weekday 0 becomes 7", v, f_cdate(5, 3, 7, 2000));

    // table: R2 R3 R4 R5 R10 R12 (both words read right after the carry edge)
    for (int i = 0; i < 12; i++) begin
      load_all(VEC[i].hh, VEC[i].mm, VEC[i].ss, VEC[i].dd, VEC[i].mo, VEC[i].wd, VEC[i].yr);
      ticks(VEC[i].nt);
      rd('h10, v);
      check("R2/R12", $sformatf("vector %0d time", i), v, f_time(VEC[i].eh, VEC[i].em, VEC[i].es));
      rd('h14, v);
      check("R3/R4/R5/R12", $sformatf("vector %0d date", i), v,
            f_cdate(VEC[i].ed, VEC[i].emo, VEC[i].ew, VEC[i].ey));
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule